// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block produces the clock line timing for an I2C bus master. From one programmed clock-control count it builds the length of the SCL low phase and the SCL high phase. The ratio between the two lengths depends on the selected speed mode and duty option. The block pulls SCL low for the low phase and then releases it. After the release it waits for the line to be seen high, and also for a programmed rise-time allowance to pass. Only then does it count the high phase. A slave that holds SCL low therefore stretches the clock without shortening the high time.

The byte engine gets two single-cycle strobes. One marks the middle of each high phase, which is where data is sampled. The other marks the middle of each low phase, which is where data may change. While the enable is low the line is released and nothing is produced. The configuration inputs must be held steady while the block is enabled.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and while `enable` is low, `scl_drive_low` is 0 and both strobes are 0.
- R2: With `fast_mode`=0, the low phase lasts C clock cycles and the high count lasts C cycles, where C is the effective count.
- R3: With `fast_mode`=1 and `duty_sel`=0, the low phase lasts 2·C cycles and the high count lasts C cycles.
- R4: With `fast_mode`=1 and `duty_sel`=1, the low phase lasts 16·C cycles and the high count lasts 9·C cycles.
- R5: The effective count C is `ccr`, raised to a floor when `ccr` is below it. The floor is 1 when `fast_mode`=1 and `duty_sel`=1, and 4 in every other mode.
- R6: When SCL is released, the high count starts only after a wait. The wait needs SCL sampled high and at least max(`trise`,1) released cycles. The released run therefore lasts max(`trise`, S+1) + high count cycles, where S is the number of released cycles during which a slave still holds `scl_in` low.
- R7: `sample_strobe` pulses once per high phase, in high-count cycle H−1−⌊H/2⌋ (0-based). `change_strobe` pulses once per low phase, in low cycle L−1−⌊L/2⌋. Neither strobe fires in the other phase.
- R8: The low phase starts in the cycle after `enable` is first sampled high. The line is released in the cycle after `enable` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator; low returns it to idle |
| fast_mode | input | 1 | 0: standard ratio, 1: fast ratios |
| duty_sel | input | 1 | In fast mode selects 2:1 (0) or 16:9 (1) low:high |
| ccr | input | 12 | Clock-control count |
| trise | input | 6 | Rise-time allowance in clock cycles |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sample_strobe | output | 1 | One-cycle pulse at mid high phase |
| change_strobe | output | 1 | One-cycle pulse at mid low phase |

## Verification
The bench runs the three ratio settings at nominal counts and then at counts below the floor. This separates the multiplier paths from the clamp, which is decided per mode. The rise wait is tested in three ways: with the line rising at once, with a large `trise`, and with a slave stretch longer than `trise`. This shows which of the two conditions ends the wait. Seeded random mixes of all of these, at odd and even lengths, check where the midpoint strobes fall.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_RISE = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

    typedef struct packed {
        logic fast;
        logic duty;
    } scl_mode_t;

    localparam int FLOOR_NORMAL  = 4;
    localparam int FLOOR_DUTY    = 1;
    localparam int LOW_SHIFT_F   = 1;   // x2
    localparam int LOW_SHIFT_FD  = 4;   // x16
    localparam int HIGH_SHIFT_FD = 3;   // x8, plus one more x1 gives x9

endpackage

// File: rtl/scl_ccr_scaler.sv
module scl_ccr_scaler
    import scl_timing_pkg::*;
#(
    parameter int CCR_W = 12,
    parameter int LEN_W = CCR_W + 4
) (
    input  scl_mode_t        mode,
    input  logic [CCR_W-1:0] ccr,
    output logic [LEN_W-1:0] low_len,
    output logic [LEN_W-1:0] high_len
);
    logic [CCR_W-1:0] floor_v;
    logic [CCR_W-1:0] eff;
    logic [LEN_W-1:0] ext;

    always_comb begin
        floor_v = (mode.fast && mode.duty) ? CCR_W'(FLOOR_DUTY) : CCR_W'(FLOOR_NORMAL);
        eff     = (ccr < floor_v) ? floor_v : ccr;
        ext     = LEN_W'(eff);
        if (!mode.fast) begin
            low_len  = ext;
            high_len = ext;
        end else if (!mode.duty) begin
            low_len  = ext << LOW_SHIFT_F;
            high_len = ext;
        end else begin
            low_len  = ext << LOW_SHIFT_FD;
            high_len = (ext << HIGH_SHIFT_FD) + ext;
        end
    end

    // R5: clamped count never yields an empty phase, and low is never shorter than high
    always_comb begin
        a_r5_len_floor: assert (high_len != '0 && low_len >= high_len);
    end

endmodule

// File: rtl/scl_rise_wait.sv
module scl_rise_wait #(
    parameter int TRISE_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic               scl_in,
    input  logic [TRISE_W-1:0] trise,
    output logic               done
);
    logic [TRISE_W-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst || !active)
            elapsed <= '0;
        else if (elapsed != '1)
            elapsed <= elapsed + TRISE_W'(1);
    end

    always_comb begin
        done = active && scl_in &&
               (({1'b0, elapsed} + (TRISE_W+1)'(1)) >= {1'b0, trise});
    end

    // R6: a line still held low never ends the wait
    a_r6_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        (active && !scl_in) |-> !done);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timing_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    input  logic             rise_done,
    output scl_phase_e       phase,
    output logic             sample_strobe,
    output logic             change_strobe
);
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] mid_pt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            mid_pt <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    phase  <= PH_LOW;
                    cnt    <= low_len - LEN_W'(1);
                    mid_pt <= low_len >> 1;
                end
                PH_LOW: begin
                    if (cnt == '0) phase <= PH_RISE;
                    else           cnt   <= cnt - LEN_W'(1);
                end
                PH_RISE: begin
                    if (rise_done) begin
                        phase  <= PH_HIGH;
                        cnt    <= high_len - LEN_W'(1);
                        mid_pt <= high_len >> 1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == '0) begin
                        phase  <= PH_LOW;
                        cnt    <= low_len - LEN_W'(1);
                        mid_pt <= low_len >> 1;
                    end else begin
                        cnt <= cnt - LEN_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign sample_strobe = (phase == PH_HIGH) && (cnt == mid_pt);
    assign change_strobe = (phase == PH_LOW)  && (cnt == mid_pt);

    // R8: disabling returns to idle on the next edge
    a_r8_idle_on_disable: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (phase == PH_IDLE));

    // R2: the low phase counts down one per cycle
    a_r2_low_countdown: assert property (@(posedge clk) disable iff (rst)
        (enable && phase == PH_LOW && cnt != '0) |=>
        (phase == PH_LOW && cnt == $past(cnt) - LEN_W'(1)));

    // R7: each strobe is a single-cycle pulse
    a_r7_sample_single: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |=> !sample_strobe);
    a_r7_change_single: assert property (@(posedge clk) disable iff (rst)
        change_strobe |=> !change_strobe);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int CCR_W   = 12,
    parameter int TRISE_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               fast_mode,
    input  logic               duty_sel,
    input  logic [CCR_W-1:0]   ccr,
    input  logic [TRISE_W-1:0] trise,
    input  logic               scl_in,
    output logic               scl_drive_low,
    output logic               sample_strobe,
    output logic               change_strobe
);
    localparam int LEN_W = CCR_W + 4;

    scl_mode_t        mode;
    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;
    logic             rise_done;
    scl_phase_e       phase;

    assign mode = '{fast: fast_mode, duty: duty_sel};

    scl_ccr_scaler #(.CCR_W(CCR_W), .LEN_W(LEN_W)) u_scaler (
        .mode     (mode),
        .ccr      (ccr),
        .low_len  (low_len),
        .high_len (high_len)
    );

    scl_rise_wait #(.TRISE_W(TRISE_W)) u_rise (
        .clk    (clk),
        .rst    (rst),
        .active (phase == PH_RISE),
        .scl_in (scl_in),
        .trise  (trise),
        .done   (rise_done)
    );

    scl_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .low_len       (low_len),
        .high_len      (high_len),
        .rise_done     (rise_done),
        .phase         (phase),
        .sample_strobe (sample_strobe),
        .change_strobe (change_strobe)
    );

    assign scl_drive_low = (phase == PH_LOW);

    // R6: the high count is only entered after the line was seen high
    a_r6_high_after_line: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIGH && $past(phase) == PH_RISE) |-> $past(scl_in));

    // R1: no strobe while the line is released for lack of enable
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (!scl_drive_low && !sample_strobe && !change_strobe));

endmodule

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        fast_mode = 1'b0;
    logic        duty_sel = 1'b0;
    logic [11:0] ccr = 12'd4;
    logic [5:0]  trise = 6'd1;
    logic        scl_in = 1'b1;
    logic        scl_drive_low, sample_strobe, change_strobe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_timing_gen u0 (
        .clk(clk), .rst(rst), .enable(enable), .fast_mode(fast_mode),
        .duty_sel(duty_sel), .ccr(ccr), .trise(trise), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .sample_strobe(sample_strobe),
        .change_strobe(change_strobe)
    );

    function automatic int eff_c(input bit f, input bit d, input int c);
        int fl = (f && d) ? 1 : 4;
        return (c < fl) ? fl : c;
    endfunction

    function automatic int exp_low(input bit f, input bit d, input int c);
        int e = eff_c(f, d, c);
        return !f ? e : (!d ? 2*e : 16*e);
    endfunction

    function automatic int exp_high(input bit f, input bit d, input int c);
        int e = eff_c(f, d, c);
        return (f && d) ? 9*e : e;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run_case(input bit f, input bit d, input int c, input int t, input int s);
        int L = exp_low(f, d, c);
        int H = exp_high(f, d, c);
        int tp = (t < 1) ? 1 : t;
        int wait_len = (tp > s + 1) ? tp : s + 1;
        string tag;
        if (c < ((f && d) ? 1 : 4)) tag = "R5";
        else if (!f) tag = "R2";
        else if (!d) tag = "R3";
        else tag = "R4";

        @(negedge clk);
        enable = 0; fast_mode = f; duty_sel = d; ccr = 12'(c); trise = 6'(t); scl_in = 1;
        @(negedge clk);
        check("R1", "idle line/strobes", {scl_drive_low, sample_strobe, change_strobe}, 0);
        enable = 1;
        @(negedge clk);
        check("R8", "low starts after enable", scl_drive_low, 1);
        for (int p = 0; p < 2; p++) begin
            int lowcnt = 0, chg_at = -1, nchg = 0, nbad = 0;
            int relcnt = 0, smp_at = -1, nsmp = 0;
            while (scl_drive_low && lowcnt < 100000) begin
                scl_in = 0;
                if (change_strobe) begin nchg++; chg_at = lowcnt; end
                if (sample_strobe) nbad++;
                lowcnt++;
                @(negedge clk);
            end
            check(tag, "low length", lowcnt, L);
            check("R7", "change strobe count", nchg, 1);
            check("R7", "change strobe position", chg_at, L - 1 - L/2);
            while (!scl_drive_low && relcnt < 100000) begin
                scl_in = (relcnt >= s);
                if (sample_strobe) begin nsmp++; smp_at = relcnt; end
                if (change_strobe) nbad++;
                relcnt++;
                @(negedge clk);
            end
            scl_in = 0;
            check((t > 1 || s > 0) ? "R6" : tag, "released length", relcnt, wait_len + H);
            check("R7", "sample strobe count", nsmp, 1);
            check("R7", "sample strobe position", smp_at, wait_len + H - 1 - H/2);
            check("R7", "strobe in wrong phase", nbad, 0);
        end
        enable = 0;
        @(negedge clk);
        check("R8", "released after disable", scl_drive_low, 0);
        scl_in = 1;
    endtask

    initial begin
        int seed = 32'h5c1;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R1", "reset line/strobes", {scl_drive_low, sample_strobe, change_strobe}, 0);
        rst = 0;
        @(negedge clk);
        check("R1", "idle after reset", {scl_drive_low, sample_strobe, change_strobe}, 0);
        // directed
        run_case(0, 0, 4, 1, 0);    // R2 minimum legal
        run_case(0, 0, 7, 1, 0);    // R2 odd
        run_case(1, 0, 6, 1, 0);    // R3
        run_case(1, 1, 1, 1, 0);    // R4 smallest
        run_case(1, 1, 3, 2, 0);    // R4
        run_case(0, 0, 0, 1, 0);    // R5 floor 4
        run_case(1, 0, 2, 1, 0);    // R5 floor 4 in fast 2:1
        run_case(1, 1, 0, 1, 0);    // R5 floor 1
        run_case(0, 0, 10, 9, 0);   // R6 rise allowance dominates
        run_case(0, 0, 10, 3, 12);  // R6 stretch dominates
        run_case(1, 0, 5, 0, 0);    // R6 zero allowance acts as one
        // random
        for (int i = 0; i < 20; i++) begin
            bit f = 1'($urandom_range(0, 1));
            bit d = 1'($urandom_range(0, 1));
            run_case(f, d, $urandom_range(0, 40), $urandom_range(0, 63), $urandom_range(0, 20));
        end
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule